// File: doc/BRIEF.md
# Processor Trap and Interrupt Controller

This block holds the control and status state of a simple in-order core: status, cause, exception PC, bad address, vector base, timer compare and retired-instruction count. Every cycle in which the core presents an instruction, the block decides whether to take a pending interrupt, take a synchronous exception, or let the instruction retire. When a trap is taken, the block raises a fetch redirect to the vector base in the same cycle. At the next edge it records the trap and switches the core into supervisor mode.

A timer interrupt is raised from the retired-instruction count. The block also reports the current privilege and the effective integer width. If an exception arrives while traps are disabled, the block latches a sticky error flag instead of vectoring. Software reaches the registers through a write port and a combinational read port.

Top module: `trap_unit`

## Requirements
- R1: After reset, cause, exception PC, bad address, vector base, compare and count read as zero. Status reads with only the supervisor bit (1) and supervisor-64 bit (6) set, or only bit 1 when wide support is disabled. `privSup` is 1 and `errMode` is 0.
- R2: Status bit 0 is trap-enable and status bits 15:8 are the interrupt mask. `redirValid` rises during an instruction cycle exactly when trap-enable is 1 and (mask AND pending) is nonzero. `redirPc` then equals the vector base.
- R3: A taken interrupt wins over an exception presented in the same cycle. It records exception code 16 and does not increment the count.
- R4: On trap entry, trap-enable is cleared and supervisor (bit 1) is set. The previous-supervisor bit (2) receives the old supervisor bit.
- R5: Cause holds the exception code in bits 4:0 and the pending field in bits 23:16. Pending bits 6:0 follow `irqLines` and pending bit 7 is the timer. A trap replaces only the code and leaves the pending bits unchanged.
- R6: A trap loads the exception PC with `curPc`. An exception trap (not an interrupt) loads the bad address with `excAddr`.
- R7: An exception presented while trap-enable is 0 sets the sticky `errMode` output. It causes no redirect and no register update. In error mode no instruction retires.
- R8: Each retired instruction increments the count. If the count before the increment equals compare, the timer pending bit is set.
- R9: A write to compare clears the timer pending bit in the same cycle. A write to cause sets the code and the timer pending bit from the written data.
- R10: Status writes clear bits 7 and 31:16. They also clear bit 3 (FPU enable) when FPU support is off, bit 4 (compressed enable) when compressed support is off, and bits 5 and 6 (user-64, supervisor-64) when wide support is off.
- R11: `wide64` is status bit 6 while in supervisor mode and status bit 5 while in user mode. `privSup` mirrors status bit 1.
- R12: Register selects are 0 status, 1 cause, 2 exception PC, 3 bad address, 4 vector base, 5 compare and 6 count. Reads are combinational. Writes take effect at the next edge and are dropped in a cycle that takes a trap or enters error mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | An instruction at `curPc` is attempted this cycle |
| curPc | input | XLEN | PC of the attempted instruction |
| excValid | input | 1 | The attempted instruction raises an exception |
| excCode | input | CODE_W | Exception code |
| excAddr | input | XLEN | Faulting virtual address |
| irqLines | input | PEND_W-1 | External interrupt levels |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register write select |
| wrData | input | XLEN | Register write data |
| rdSel | input | 3 | Register read select |
| rdData | output | XLEN | Register read data |
| redirValid | output | 1 | Fetch redirect to trap vector this cycle |
| redirPc | output | XLEN | Redirect target |
| privSup | output | 1 | Current privilege is supervisor |
| wide64 | output | 1 | Effective integer width is 64 |
| errMode | output | 1 | Sticky error mode |

## Verification
The main instance is built with XLEN=32 and FPU support off, with compressed and wide support on. This makes the status filter observable in both directions. With 32-bit registers, count and compare values stay short enough for timer matches to be walked a step at a time. The small configuration also allows a sweep over all 256 mask values against all 128 external line patterns. A second instance is built with every feature off so that the narrow reset status and the 32-bit width can be checked.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int ST_ET      = 0;
  localparam int ST_SUP     = 1;
  localparam int ST_PSUP    = 2;
  localparam int ST_FPU     = 3;
  localparam int ST_COMP    = 4;
  localparam int ST_U64     = 5;
  localparam int ST_S64     = 6;
  localparam int ST_MASK_LO = 8;
  localparam int ST_W       = 32;
  localparam int CAUSE_PEND_LO = 16;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_CAUSE  = 3'd1,
    SEL_EPC    = 3'd2,
    SEL_BAD    = 3'd3,
    SEL_VEC    = 3'd4,
    SEL_CMP    = 3'd5,
    SEL_CNT    = 3'd6
  } regSel_e;

  typedef struct packed {
    logic trapGo;
    logic irqTrap;
    logic excTrap;
    logic retire;
    logic wrOk;
  } ctlStrobe_t;
endpackage

// File: rtl/trap_control.sv
module trap_control
  import trap_pkg::*;
#(
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic              excValid,
  input  logic              trapEn,
  input  logic [PEND_W-1:0] mask,
  input  logic [PEND_W-1:0] pend,
  output ctlStrobe_t        st,
  output logic              errMode
);
  logic irqHit;
  logic excHit;
  logic enterErr;

  always_comb begin
    irqHit   = instrValid && !errMode && trapEn && (|(mask & pend));
    excHit   = instrValid && !errMode && excValid && !irqHit;
    enterErr = excHit && !trapEn;
    st.irqTrap = irqHit;
    st.excTrap = excHit && trapEn;
    st.trapGo  = irqHit || (excHit && trapEn);
    st.retire  = instrValid && !errMode && !excValid && !irqHit;
    st.wrOk    = !st.trapGo && !enterErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errMode <= 1'b0;
    else if (enterErr) errMode <= 1'b1;
  end
endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int PEND_W   = 8,
  parameter int CODE_W   = 5,
  parameter int IRQ_CODE = 16,
  parameter bit HAS_WIDE = 1'b1,
  parameter bit HAS_FPU  = 1'b1,
  parameter bit HAS_COMP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        st,
  input  logic [XLEN-1:0]   curPc,
  input  logic [CODE_W-1:0] excCode,
  input  logic [XLEN-1:0]   excAddr,
  input  logic [PEND_W-2:0] irqLines,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [XLEN-1:0]   wrData,
  input  logic [2:0]        rdSel,
  output logic [XLEN-1:0]   rdData,
  output logic [XLEN-1:0]   redirPc,
  output logic              trapEn,
  output logic              privSup,
  output logic              wide64,
  output logic [PEND_W-1:0] mask,
  output logic [PEND_W-1:0] pend,
  output logic [XLEN-1:0]   epcQ,
  output logic [XLEN-1:0]   cntQ,
  output logic              timerPend
);
  function automatic logic [ST_W-1:0] legalBits();
    logic [ST_W-1:0] m;
    m = '0;
    m[ST_ET]   = 1'b1;
    m[ST_SUP]  = 1'b1;
    m[ST_PSUP] = 1'b1;
    m[ST_MASK_LO +: PEND_W] = '1;
    if (HAS_FPU)  m[ST_FPU]  = 1'b1;
    if (HAS_COMP) m[ST_COMP] = 1'b1;
    if (HAS_WIDE) begin
      m[ST_U64] = 1'b1;
      m[ST_S64] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [ST_W-1:0] LEGAL    = legalBits();
  localparam logic [ST_W-1:0] RESET_ST = ((ST_W'(1) << ST_SUP) | (ST_W'(1) << ST_S64)) & LEGAL;
  localparam logic [CODE_W-1:0] IRQ_C  = CODE_W'(IRQ_CODE);

  logic [ST_W-1:0]   statusQ;
  logic [ST_W-1:0]   trapStatus;
  logic [CODE_W-1:0] codeQ;
  logic [XLEN-1:0]   badQ;
  logic [XLEN-1:0]   vecQ;
  logic [XLEN-1:0]   cmpQ;
  logic [XLEN-1:0]   causeRd;
  logic              wrHit;

  assign wrHit   = st.wrOk && wrEn;
  assign pend    = {timerPend, irqLines};
  assign mask    = statusQ[ST_MASK_LO +: PEND_W];
  assign trapEn  = statusQ[ST_ET];
  assign privSup = statusQ[ST_SUP];
  assign wide64  = statusQ[ST_SUP] ? statusQ[ST_S64] : statusQ[ST_U64];
  assign redirPc = vecQ;

  always_comb begin
    trapStatus = statusQ;
    trapStatus[ST_ET]   = 1'b0;
    trapStatus[ST_PSUP] = statusQ[ST_SUP];
    trapStatus[ST_SUP]  = 1'b1;
  end

  always_comb begin
    causeRd = '0;
    causeRd[CODE_W-1:0] = codeQ;
    causeRd[CAUSE_PEND_LO +: PEND_W] = pend;
  end

  always_comb begin
    case (rdSel)
      SEL_STATUS: rdData = XLEN'(statusQ);
      SEL_CAUSE:  rdData = causeRd;
      SEL_EPC:    rdData = epcQ;
      SEL_BAD:    rdData = badQ;
      SEL_VEC:    rdData = vecQ;
      SEL_CMP:    rdData = cmpQ;
      SEL_CNT:    rdData = cntQ;
      default:    rdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= RESET_ST;
      codeQ   <= '0;
      epcQ    <= '0;
      badQ    <= '0;
      vecQ    <= '0;
      cmpQ    <= '0;
    end else begin
      if (st.trapGo) begin
        statusQ <= trapStatus;
        codeQ   <= st.irqTrap ? IRQ_C : excCode;
        epcQ    <= curPc;
        if (st.excTrap) badQ <= excAddr;
      end
      if (wrHit) begin
        case (wrSel)
          SEL_STATUS: statusQ <= wrData[ST_W-1:0] & LEGAL;
          SEL_CAUSE:  codeQ   <= wrData[CODE_W-1:0];
          SEL_EPC:    epcQ    <= wrData;
          SEL_BAD:    badQ    <= wrData;
          SEL_VEC:    vecQ    <= wrData;
          SEL_CMP:    cmpQ    <= wrData;
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else if (wrHit && wrSel == SEL_CNT) cntQ <= wrData;
    else if (st.retire) cntQ <= cntQ + XLEN'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) timerPend <= 1'b0;
    else if (wrHit && wrSel == SEL_CMP) timerPend <= 1'b0;
    else if (wrHit && wrSel == SEL_CAUSE) timerPend <= wrData[CAUSE_PEND_LO + PEND_W - 1];
    else if (st.retire && cntQ == cmpQ) timerPend <= 1'b1;
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int PEND_W   = 8,
  parameter int CODE_W   = 5,
  parameter int IRQ_CODE = 16,
  parameter bit HAS_WIDE = 1'b1,
  parameter bit HAS_FPU  = 1'b1,
  parameter bit HAS_COMP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [XLEN-1:0]   curPc,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic [XLEN-1:0]   excAddr,
  input  logic [PEND_W-2:0] irqLines,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [XLEN-1:0]   wrData,
  input  logic [2:0]        rdSel,
  output logic [XLEN-1:0]   rdData,
  output logic              redirValid,
  output logic [XLEN-1:0]   redirPc,
  output logic              privSup,
  output logic              wide64,
  output logic              errMode
);
  ctlStrobe_t        st;
  logic              trapEn;
  logic [PEND_W-1:0] mask;
  logic [PEND_W-1:0] pend;
  logic [XLEN-1:0]   epcQ;
  logic [XLEN-1:0]   cntQ;
  logic              timerPend;

  assign redirValid = st.trapGo;

  trap_control #(.PEND_W(PEND_W)) ctl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .excValid(excValid),
    .trapEn(trapEn), .mask(mask), .pend(pend), .st(st), .errMode(errMode)
  );

  trap_datapath #(
    .XLEN(XLEN), .PEND_W(PEND_W), .CODE_W(CODE_W), .IRQ_CODE(IRQ_CODE),
    .HAS_WIDE(HAS_WIDE), .HAS_FPU(HAS_FPU), .HAS_COMP(HAS_COMP)
  ) dp (
    .clk(clk), .rstN(rstN), .st(st), .curPc(curPc), .excCode(excCode),
    .excAddr(excAddr), .irqLines(irqLines), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .redirPc(redirPc),
    .trapEn(trapEn), .privSup(privSup), .wide64(wide64), .mask(mask),
    .pend(pend), .epcQ(epcQ), .cntQ(cntQ), .timerPend(timerPend)
  );
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            instrValid,
  input logic            excValid,
  input logic [XLEN-1:0] curPc,
  input logic            wrEn,
  input logic [2:0]      wrSel,
  input logic            redirValid,
  input logic            errMode,
  input logic            privSup,
  input logic            trapEn,
  input logic [XLEN-1:0] epcQ,
  input logic [XLEN-1:0] cntQ,
  input logic            timerPend
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errMode |=> errMode); // R7
  AST_ERR_NO_REDIR: assert property (@(posedge clk) disable iff (!rstN)
    errMode |-> !redirValid); // R7
  AST_TRAP_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> (privSup && !trapEn)); // R4
  AST_TRAP_EPC: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> (epcQ == $past(curPc))); // R6
  AST_RETIRE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !excValid && !redirValid && !errMode && !wrEn) |=> (cntQ == $past(cntQ) + XLEN'(1))); // R8
  AST_CMP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 3'd5 && !instrValid) |=> !timerPend); // R9
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN)) chk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .excValid(excValid),
  .curPc(curPc), .wrEn(wrEn), .wrSel(wrSel), .redirValid(redirValid),
  .errMode(errMode), .privSup(privSup), .trapEn(trapEn), .epcQ(epcQ),
  .cntQ(cntQ), .timerPend(timerPend)
);

// File: tb/trap_unit_test.sv
`timescale 1ns/1ps
module trap_unit_test;
  localparam logic [2:0] R_ST = 3'd0, R_CA = 3'd1, R_EPC = 3'd2, R_BAD = 3'd3,
                         R_VEC = 3'd4, R_CMP = 3'd5, R_CNT = 3'd6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0, excValid = 1'b0, wrEn = 1'b0;
  logic [31:0] curPc = '0, excAddr = '0, wrData = '0;
  logic [4:0] excCode = '0;
  logic [6:0] irqLines = '0;
  logic [2:0] wrSel = '0, rdSel = '0;
  logic [31:0] rdData, redirPc, rdDataN, redirPcN;
  logic redirValid, privSup, wide64, errMode;
  logic redirValidN, privSupN, wide64N, errModeN;
  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  trap_unit #(.XLEN(32), .HAS_WIDE(1'b1), .HAS_FPU(1'b0), .HAS_COMP(1'b1)) uut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .curPc(curPc),
    .excValid(excValid), .excCode(excCode), .excAddr(excAddr), .irqLines(irqLines),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .redirValid(redirValid), .redirPc(redirPc), .privSup(privSup),
    .wide64(wide64), .errMode(errMode));

  trap_unit #(.XLEN(32), .HAS_WIDE(1'b0), .HAS_FPU(1'b0), .HAS_COMP(1'b0)) uutNarrow (
    .clk(clk), .rstN(rstN), .instrValid(1'b0), .curPc(curPc),
    .excValid(1'b0), .excCode(excCode), .excAddr(excAddr), .irqLines(irqLines),
    .wrEn(1'b0), .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdDataN),
    .redirValid(redirValidN), .redirPc(redirPcN), .privSup(privSupN),
    .wide64(wide64N), .errMode(errModeN));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    rdSel = s;
    #0.1;
    v = rdData;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = s; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic instr(input logic exc, input logic [4:0] code, input logic [31:0] addr,
                       input logic [31:0] pc, output logic rv, output logic [31:0] rp);
    @(negedge clk);
    instrValid = 1'b1; excValid = exc; excCode = code; excAddr = addr; curPc = pc;
    #1 rv = redirValid; rp = redirPc;
    @(posedge clk);
    #1 instrValid = 1'b0; excValid = 1'b0;
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [31:0] v;
    logic rv;
    logic [31:0] rp;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1, R12 reset readback
    rd(R_ST, v);  check("R1 status", v, 32'h42);
    rd(R_CA, v);  check("R1 cause", v, 0);
    rd(R_EPC, v); check("R1 epc", v, 0);
    rd(R_BAD, v); check("R1 bad", v, 0);
    rd(R_VEC, v); check("R12 vec", v, 0);
    rd(R_CMP, v); check("R1 cmp", v, 0);
    rd(R_CNT, v); check("R1 cnt", v, 0);
    check("R1 priv", {31'b0, privSup}, 1);
    check("R1 err", {31'b0, errMode}, 0);
    check("R11 wide reset", {31'b0, wide64}, 1);
    rdSel = R_ST; #0.1;
    check("R1 narrow status", rdDataN, 32'h2);
    check("R11 narrow wide", {31'b0, wide64N}, 0);

    // R8 first retire: count 0 equals compare 0
    instr(1'b0, 0, 0, 32'h100, rv, rp);
    check("R8 no redirect", {31'b0, rv}, 0);
    rd(R_CNT, v); check("R8 cnt", v, 1);
    rd(R_CA, v);  check("R8 timer set", v, 32'h0080_0000);

    // R9 compare write clears timer
    wr(R_CMP, 5);
    rd(R_CA, v);  check("R9 cmp clears", v, 0);
    for (int i = 0; i < 4; i++) instr(1'b0, 0, 0, 32'h104, rv, rp);
    rd(R_CNT, v); check("R8 cnt5", v, 5);
    rd(R_CA, v);  check("R8 no early timer", v, 0);
    instr(1'b0, 0, 0, 32'h108, rv, rp);
    rd(R_CNT, v); check("R8 cnt6", v, 6);
    rd(R_CA, v);  check("R8 timer at match", v, 32'h0080_0000);
    wr(R_CMP, 1000);
    rd(R_CA, v);  check("R9 clear again", v, 0);
    wr(R_CA, 32'h0080_0003);
    rd(R_CA, v);  check("R9 cause write", v, 32'h0080_0003);
    wr(R_CMP, 1000);

    // R10 status filter
    wr(R_ST, 32'hFFFF_FFFF);
    rd(R_ST, v); check("R10 filter", v, 32'h0000_FF77);

    // R11 width over privilege and width bits
    for (int k = 0; k < 8; k++) begin
      logic sup, u64, s64;
      sup = k[0]; u64 = k[1]; s64 = k[2];
      wr(R_ST, {25'b0, s64, u64, 3'b0, sup, 1'b0});
      #0.5;
      check("R11 wide", {31'b0, wide64}, {31'b0, sup ? s64 : u64});
      check("R11 priv", {31'b0, privSup}, {31'b0, sup});
    end

    // R2 sweep of mask against external lines
    wr(R_VEC, 32'h400);
    for (int m = 0; m < 256; m++) begin
      wr(R_ST, (32'(m) << 8) | 32'h3);
      for (int l = 0; l < 128; l++) begin
        @(negedge clk);
        irqLines = 7'(l); instrValid = 1'b1; curPc = 32'h200;
        #1;
        check("R2 gate", {31'b0, redirValid}, {31'b0, |(8'(m) & {1'b0, 7'(l)})});
        if (redirValid) check("R2 target", redirPc, 32'h400);
        instrValid = 1'b0;
      end
    end
    irqLines = '0;
    wr(R_CA, 32'h0080_0000);
    wr(R_ST, 32'h0000_8003);
    @(negedge clk); instrValid = 1'b1; #1;
    check("R2 timer irq", {31'b0, redirValid}, 1);
    instrValid = 1'b0;
    wr(R_ST, 32'h0000_7F03);
    @(negedge clk); instrValid = 1'b1; #1;
    check("R2 timer masked", {31'b0, redirValid}, 0);
    instrValid = 1'b0;
    wr(R_ST, 32'h0000_FF02);
    @(negedge clk); instrValid = 1'b1; irqLines = 7'h7F; #1;
    check("R2 disabled", {31'b0, redirValid}, 0);
    instrValid = 1'b0; irqLines = '0;
    wr(R_CMP, 1000);

    // R3 interrupt from user mode, preempts exception
    wr(R_CNT, 50);
    wr(R_ST, 32'h0000_0101);
    irqLines = 7'h01;
    instr(1'b1, 5'd9, 32'hBEEF, 32'h200, rv, rp);
    check("R3 taken", {31'b0, rv}, 1);
    rd(R_CNT, v); check("R3 no count", v, 50);
    rd(R_CA, v);  check("R5 irq code kept pend", v, 32'h0001_0010);
    rd(R_EPC, v); check("R6 epc irq", v, 32'h200);
    rd(R_BAD, v); check("R6 bad untouched", v, 0);
    rd(R_ST, v);  check("R4 from user", v, 32'h0000_0102);
    irqLines = '0;

    // R4, R5, R6 exception from supervisor with timer pending
    wr(R_ST, 32'h0000_0003);
    wr(R_CA, 32'h0080_0000);
    instr(1'b1, 5'd7, 32'h000D_EAD0, 32'h300, rv, rp);
    check("R6 redirect", {31'b0, rv}, 1);
    check("R6 target", rp, 32'h400);
    rd(R_ST, v);  check("R4 from sup", v, 32'h6);
    rd(R_CA, v);  check("R5 code only", v, 32'h0080_0007);
    rd(R_EPC, v); check("R6 epc", v, 32'h300);
    rd(R_BAD, v); check("R6 bad", v, 32'h000D_EAD0);
    rd(R_CNT, v); check("R6 no count", v, 50);
    wr(R_CMP, 1000);

    // R7 exception with traps disabled, write in same cycle dropped
    @(negedge clk);
    instrValid = 1'b1; excValid = 1'b1; excCode = 5'd3; curPc = 32'h500;
    wrEn = 1'b1; wrSel = R_VEC; wrData = 32'h900;
    #1 check("R7 no redirect", {31'b0, redirValid}, 0);
    @(posedge clk);
    #1 instrValid = 1'b0; excValid = 1'b0; wrEn = 1'b0;
    check("R7 err set", {31'b0, errMode}, 1);
    rd(R_EPC, v); check("R7 epc kept", v, 32'h300);
    rd(R_ST, v);  check("R7 status kept", v, 32'h6);
    rd(R_VEC, v); check("R12 write dropped", v, 32'h400);
    instr(1'b0, 0, 0, 32'h504, rv, rp);
    rd(R_CNT, v); check("R7 no retire", v, 50);
    check("R7 sticky", {31'b0, errMode}, 1);

    finish();
  end
endmodule